// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block steers the feedback divider of a fractional-N synthesizer built around an eight/nine dual-modulus prescaler. Software-visible words N, S and F set the mean division ratio to 8·(N+3) + S + F/18. On every reference-rate tick the block emits one integer divide value and a modulus-control bit. A phase accumulator that wraps at 18, not at a power of two, adds one extra count on F of every 18 ticks. With an 18 MHz reference, each unit of F therefore moves the output by 1 MHz. A setting of 2206 MHz, for example, is an integer part of 122 plus 10/18.

New words are staged and only become active on the tick that closes an 18-tick accumulator cycle. This keeps every cycle's total count exact. From the active F the block also reports where the fractional spurs fall. They sit at F and at 18−F steps of ref/18 from the carrier, and the closest-in pair (F of 1 or 17) is flagged. A second, lower-band synthesizer can reuse the same sequencer and divide its output by a further 8, which gives a 125 kHz step from an 18 MHz reference.

Top module: `frac_div_sequencer`

## Requirements
- R1: After synchronous reset, div_vld, mod_ctl, cfg_clamp and spur_on are 0, and the active words are N=0, S=0, F=0, so the divide value is 24.
- R2: A cycle with ref_tick high is followed in the next cycle by div_vld high, with div_val = 8·(N+3) + S + carry. div_vld is low after any cycle without a tick.
- R3: On each tick the accumulator adds F. When the sum is 18 or more, 18 is subtracted and the carry (shown on mod_ctl with that tick's div_val) is 1. mod_ctl is 0 whenever div_vld is 0.
- R4: Over every 18-tick accumulator cycle, the div_val outputs add up to exactly 18·(8·(N+3)+S) + F.
- R5: An S input of 8 or more is replaced by 7, and cfg_clamp is high while that word set is active.
- R6: An F input of 18 or more is replaced by 17, and cfg_clamp is high while that word set is active.
- R7: A word set loaded with cfg_load becomes active only on the tick that ends an 18-tick cycle. That tick still uses the old words, and the accumulator restarts from zero.
- R8: With active F non-zero, spur_on is 1, spur_lo = F and spur_hi = 18−F (units of ref/18). With F = 0, all three are 0.
- R9: spur_worst is 1 exactly when the active F is 1 or 17.
- R10: A second cfg_load before the boundary replaces the staged words, so only the last one loaded becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One pulse per reference cycle |
| cfg_load | input | 1 | Stage the words below |
| cfg_n | input | 8 | Integer word N |
| cfg_s | input | 4 | Swallow word S (valid 0..7) |
| cfg_f | input | 5 | Fraction word F (valid 0..17) |
| div_vld | output | 1 | div_val/mod_ctl valid for one tick |
| div_val | output | 12 | Integer divide value for this tick |
| mod_ctl | output | 1 | Accumulator carry for this tick |
| cfg_clamp | output | 1 | Active words were clamped |
| spur_on | output | 1 | Fractional spurs present |
| spur_lo | output | 5 | First spur offset, ref/18 units |
| spur_hi | output | 5 | Second spur offset, ref/18 units |
| spur_worst | output | 1 | Spur offset is one step |

## Verification
div_val, mod_ctl and div_vld are due one clock after the edge that samples a tick. Words staged by cfg_load show on cfg_clamp and the spur outputs one clock after the edge that samples the cycle-ending tick, and they first shape div_val on the tick after that. The bench drives all inputs on falling edges and advances a behavioural model on the same rising edges as the design. It compares every output on the following falling edge, where all of these results are already settled. Per-cycle totals are summed from the observed div_val and compared when the model marks a cycle end.

// File: rtl/frac_pkg.sv
package frac_pkg;

    localparam int N_W   = 8;
    localparam int S_W   = 4;
    localparam int F_W   = 5;
    localparam int MOD   = 18;
    localparam int PRESC = 8;
    localparam int NOFF  = 3;

    localparam int SI_W  = $clog2(PRESC);
    localparam int PH_W  = $clog2(MOD);
    localparam int SUM_W = PH_W + 1;
    localparam int DIV_MAX = PRESC * ((1 << N_W) - 1 + NOFF) + PRESC;
    localparam int DIV_W = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic [N_W-1:0]  n;
        logic [SI_W-1:0] s;
        logic [PH_W-1:0] f;
    } ratio_cfg_t;

    function automatic logic [SI_W-1:0] sat_swallow(input logic [S_W-1:0] s);
        if (s > S_W'(PRESC - 1)) return SI_W'(PRESC - 1);
        return s[SI_W-1:0];
    endfunction

    function automatic logic [PH_W-1:0] sat_frac(input logic [F_W-1:0] f);
        if (f > F_W'(MOD - 1)) return PH_W'(MOD - 1);
        return f[PH_W-1:0];
    endfunction

    function automatic logic [DIV_W-1:0] whole_ratio(input ratio_cfg_t c);
        return DIV_W'(PRESC * (int'(c.n) + NOFF) + int'(c.s));
    endfunction

endpackage

// File: rtl/frac_cfg_stage.sv
module frac_cfg_stage
    import frac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [N_W-1:0]   raw_n,
    input  logic [S_W-1:0]   raw_s,
    input  logic [F_W-1:0]   raw_f,
    input  logic             cyc_end,
    output ratio_cfg_t       active,
    output logic             act_clamp,
    output logic             swap
);
    ratio_cfg_t staged;
    logic       staged_clamp;
    logic       staged_v;

    assign swap = cyc_end && staged_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged       <= '0;
            staged_clamp <= 1'b0;
            staged_v     <= 1'b0;
            active       <= '0;
            act_clamp    <= 1'b0;
        end else begin
            if (swap) begin
                active    <= staged;
                act_clamp <= staged_clamp;
            end
            if (cfg_load) begin
                staged.n     <= raw_n;
                staged.s     <= sat_swallow(raw_s);
                staged.f     <= sat_frac(raw_f);
                staged_clamp <= (raw_s > S_W'(PRESC - 1)) || (raw_f > F_W'(MOD - 1));
                staged_v     <= 1'b1;
            end else if (swap) begin
                staged_v     <= 1'b0;
            end
        end
    end

    // R7: the active word set changes only right after a boundary swap
    assert_swap_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> $past(swap));

    // R6: the fraction that reaches the accumulator is always below the modulus
    assert_frac_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        active.f < PH_W'(MOD));

endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc
    import frac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PH_W-1:0]  frac,
    input  logic             clr,
    output logic             carry_now,
    output logic             cyc_end
);
    logic [PH_W-1:0]  acc;
    logic [PH_W-1:0]  phase;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_wrapped;

    assign sum         = {1'b0, acc} + {1'b0, frac};
    assign carry_now   = tick && (sum >= SUM_W'(MOD));
    assign sum_wrapped = (sum >= SUM_W'(MOD)) ? (sum - SUM_W'(MOD)) : sum;
    assign cyc_end     = tick && (phase == PH_W'(MOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            phase <= '0;
        end else if (tick) begin
            phase <= cyc_end ? '0 : phase + 1'b1;
            acc   <= clr ? '0 : sum_wrapped[PH_W-1:0];
        end
    end

    // carries seen so far in the current accumulator cycle
    logic [PH_W-1:0] carry_seen;
    always_ff @(posedge clk) begin
        if (rst || cyc_end) carry_seen <= '0;
        else if (carry_now) carry_seen <= carry_seen + 1'b1;
    end

    // R3: the wrapped accumulator never holds the modulus or more
    assert_acc_below_mod_R3: assert property (@(posedge clk) disable iff (rst)
        acc < PH_W'(MOD));

    // R4: a full cycle carries exactly F times
    assert_cycle_carries_R4: assert property (@(posedge clk) disable iff (rst)
        cyc_end |-> (carry_seen + PH_W'(carry_now)) == frac);

endmodule

// File: rtl/frac_div_out.sv
module frac_div_out
    import frac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              carry_now,
    input  ratio_cfg_t        active,
    output logic              div_vld,
    output logic [DIV_W-1:0]  div_val,
    output logic              mod_ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            div_vld <= 1'b0;
            mod_ctl <= 1'b0;
            div_val <= whole_ratio('0);
        end else begin
            div_vld <= tick;
            mod_ctl <= carry_now;
            if (tick) div_val <= whole_ratio(active) + DIV_W'(carry_now);
        end
    end

    // R2: a valid divide value only ever follows a tick
    assert_vld_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
        div_vld |-> $past(tick));

    // R3: modulus control is never raised outside a valid slot
    assert_mod_in_slot_R3: assert property (@(posedge clk) disable iff (rst)
        mod_ctl |-> div_vld);

endmodule

// File: rtl/frac_spur_calc.sv
module frac_spur_calc
    import frac_pkg::*;
(
    input  logic [PH_W-1:0] frac,
    output logic            spur_on,
    output logic [PH_W-1:0] spur_lo,
    output logic [PH_W-1:0] spur_hi,
    output logic            spur_worst
);
    always_comb begin
        spur_on    = (frac != '0);
        spur_lo    = spur_on ? frac : '0;
        spur_hi    = spur_on ? (PH_W'(MOD) - frac) : '0;
        spur_worst = (frac == PH_W'(1)) || (frac == PH_W'(MOD - 1));
    end
endmodule

// File: rtl/frac_div_sequencer.sv
module frac_div_sequencer
    import frac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              cfg_load,
    input  logic [N_W-1:0]    cfg_n,
    input  logic [S_W-1:0]    cfg_s,
    input  logic [F_W-1:0]    cfg_f,
    output logic              div_vld,
    output logic [DIV_W-1:0]  div_val,
    output logic              mod_ctl,
    output logic              cfg_clamp,
    output logic              spur_on,
    output logic [PH_W-1:0]   spur_lo,
    output logic [PH_W-1:0]   spur_hi,
    output logic              spur_worst
);
    ratio_cfg_t active;
    logic       swap;
    logic       cyc_end;
    logic       carry_now;

    frac_cfg_stage u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .raw_n     (cfg_n),
        .raw_s     (cfg_s),
        .raw_f     (cfg_f),
        .cyc_end   (cyc_end),
        .active    (active),
        .act_clamp (cfg_clamp),
        .swap      (swap)
    );

    frac_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_tick),
        .frac      (active.f),
        .clr       (swap),
        .carry_now (carry_now),
        .cyc_end   (cyc_end)
    );

    frac_div_out u_out (
        .clk       (clk),
        .rst       (rst),
        .tick      (ref_tick),
        .carry_now (carry_now),
        .active    (active),
        .div_vld   (div_vld),
        .div_val   (div_val),
        .mod_ctl   (mod_ctl)
    );

    frac_spur_calc u_spur (
        .frac       (active.f),
        .spur_on    (spur_on),
        .spur_lo    (spur_lo),
        .spur_hi    (spur_hi),
        .spur_worst (spur_worst)
    );

    // R9: the one-step spur case always implies spurs are present
    assert_worst_has_spur_R9: assert property (@(posedge clk) disable iff (rst)
        spur_worst |-> spur_on);

endmodule

// File: tb/frac_div_sequencer_bench.sv
module frac_div_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_n = '0;
    logic [3:0]  cfg_s = '0;
    logic [4:0]  cfg_f = '0;
    logic        div_vld;
    logic [11:0] div_val;
    logic        mod_ctl;
    logic        cfg_clamp;
    logic        spur_on;
    logic [4:0]  spur_lo;
    logic [4:0]  spur_hi;
    logic        spur_worst;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_div_sequencer u_frac_div_sequencer (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_load(cfg_load),
        .cfg_n(cfg_n), .cfg_s(cfg_s), .cfg_f(cfg_f),
        .div_vld(div_vld), .div_val(div_val), .mod_ctl(mod_ctl),
        .cfg_clamp(cfg_clamp), .spur_on(spur_on), .spur_lo(spur_lo),
        .spur_hi(spur_hi), .spur_worst(spur_worst)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int a_n = 0, a_s = 0, a_f = 0, a_cl = 0;
    int p_n = 0, p_s = 0, p_f = 0, p_cl = 0, p_v = 0;
    int m_acc = 0, m_ph = 0;
    int e_vld = 0, e_val = 24, e_mod = 0;
    int e_end = 0, e_total = 0;
    int obs_sum = 0;

    always @(posedge clk) begin
        if (rst) begin
            a_n = 0; a_s = 0; a_f = 0; a_cl = 0;
            p_v = 0; m_acc = 0; m_ph = 0;
            e_vld = 0; e_val = 24; e_mod = 0; e_end = 0;
        end else begin
            int sw;
            sw = 0;
            e_vld = ref_tick;
            e_mod = 0;
            e_end = 0;
            if (ref_tick) begin
                m_acc = m_acc + a_f;
                if (m_acc >= 18) begin
                    m_acc = m_acc - 18;
                    e_mod = 1;
                end
                e_val = 8 * (a_n + 3) + a_s + e_mod;
                if (m_ph == 17) begin
                    e_end = 1;
                    e_total = 18 * (8 * (a_n + 3) + a_s) + a_f;
                    m_ph = 0;
                    if (p_v != 0) begin
                        sw = 1;
                        a_n = p_n; a_s = p_s; a_f = p_f; a_cl = p_cl;
                        m_acc = 0;
                    end
                end else begin
                    m_ph = m_ph + 1;
                end
            end
            if (cfg_load) begin
                p_n = cfg_n;
                p_s = (cfg_s > 7) ? 7 : cfg_s;
                p_f = (cfg_f > 17) ? 17 : cfg_f;
                p_cl = (cfg_s > 7 || cfg_f > 17) ? 1 : 0;
                p_v = 1;
            end else if (sw != 0) begin
                p_v = 0;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check(div_vld == e_vld[0], "R2 div_vld", div_vld, e_vld);
            if (e_vld != 0) begin
                check(div_val == e_val, "R2 div_val", div_val, e_val);
                obs_sum += div_val;
            end
            check(mod_ctl == e_mod[0], "R3 mod_ctl", mod_ctl, e_mod);
            if (e_end != 0) begin
                check(obs_sum == e_total, "R4 cycle total", obs_sum, e_total);
                obs_sum = 0;
            end
            check(cfg_clamp == a_cl[0], "R5/R6 cfg_clamp", cfg_clamp, a_cl);
            check(spur_on == (a_f != 0), "R8 spur_on", spur_on, (a_f != 0));
            check(spur_lo == ((a_f != 0) ? a_f : 0), "R8 spur_lo", spur_lo, a_f);
            check(spur_hi == ((a_f != 0) ? 18 - a_f : 0), "R8 spur_hi", spur_hi,
                  (a_f != 0) ? 18 - a_f : 0);
            check(spur_worst == (a_f == 1 || a_f == 17), "R9 spur_worst", spur_worst,
                  (a_f == 1 || a_f == 17));
        end else begin
            obs_sum = 0;
        end
    end

    task automatic tick_once();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic ticks(input int k, input int gap);
        for (int i = 0; i < k; i++) begin
            tick_once();
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic burst(input int k);
        @(negedge clk) ref_tick = 1'b1;
        repeat (k) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic load(input int n, input int s, input int f);
        @(negedge clk);
        cfg_load = 1'b1; cfg_n = 8'(n); cfg_s = 4'(s); cfg_f = 5'(f);
        @(negedge clk) cfg_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(div_vld == 1'b0, "R1 div_vld", div_vld, 0);
        check(mod_ctl == 1'b0, "R1 mod_ctl", mod_ctl, 0);
        check(spur_on == 1'b0, "R1 spur_on", spur_on, 0);
        check(cfg_clamp == 1'b0, "R1 cfg_clamp", cfg_clamp, 0);
        check(div_val == 12'd24, "R1 div_val", div_val, 24);

        // R7: staged words wait for the boundary
        ticks(5, 1);
        load(12, 2, 10);
        tick_once();
        check(div_val == 12'd24, "R7 old words before boundary", div_val, 24);
        ticks(12, 0);
        tick_once();
        check(div_val == 12'd122, "R7 new words after boundary", div_val, 122);
        ticks(17, 2);

        // R10: last staged load wins
        load(5, 1, 1);
        load(5, 3, 17);
        ticks(18, 1);
        check(spur_lo == 5'd17, "R10 spur_lo", spur_lo, 17);
        check(spur_hi == 5'd1, "R10 spur_hi", spur_hi, 1);
        check(spur_worst == 1'b1, "R9 worst at F=17", spur_worst, 1);

        // R5 / R6: clamping, continuous ticks
        load(0, 12, 25);
        burst(18);
        @(negedge clk);
        check(cfg_clamp == 1'b1, "R5 clamp flag", cfg_clamp, 1);
        check(spur_lo == 5'd17, "R6 F clamped", spur_lo, 17);
        tick_once();
        check(div_val == 12'd31, "R5 S clamped", div_val, 31);
        ticks(17, 0);

        // R8: zero fraction
        load(200, 0, 0);
        ticks(18, 2);
        check(spur_on == 1'b0, "R8 no spur at F=0", spur_on, 0);
        burst(36);
        load(255, 7, 9);
        burst(18);
        ticks(36, 1);
        load(3, 4, 1);
        ticks(18, 0);
        ticks(20, 3);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule